// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides a fast clock by a programmable ratio N and emits one single-clock pulse per N input clocks for the phase comparator. The division is split between a two-modulus prescaler, which counts either P or P+1 input clocks per cycle, and a pair of down-counters. The swallow counter (A) decides how many prescaler cycles run in the P+1 modulus. The main counter (B) decides the total number of prescaler cycles per output period. The ratio is therefore N = P*B + A. For example, P=8, A=4 and B=687 give N=5500.

A validator checks the requested setting on every clock and blocks output pulses while the setting is illegal. A freeze input and a SYNC input can stop and realign the counters. Ratio changes made in the middle of a period are applied at the next period boundary, so a period that has already started is never cut short.

The control flow is a three-state machine:
- HOLD: counters cleared, no output.
- SWALLOW: the prescaler runs at P+1.
- MAIN: the prescaler runs at P.

It has these named transitions:
- START: from HOLD to SWALLOW, or to MAIN when A=0. Taken when nothing stops the divider.
- DRAIN: from SWALLOW to MAIN. Taken when the last swallow cycle ends.
- WRAP: from MAIN back to SWALLOW or MAIN. Taken at the terminal count, which also reloads the counters.
- HALT: from SWALLOW or MAIN to HOLD. Taken on freeze, on SYNC with counter reset enabled, or on an illegal setting.

Top module: `fdiv_dual_mod`

## Requirements
- R1: The prescaler mode `psc_mode` selects 0 = 8/9, 1 = 16/17 and 2 = 32/33. Successive `div_pulse` rising points are exactly N = P*B + A input clocks apart, where P is 8, 16 or 32.
- R2: `div_pulse` is high for exactly one clock per period.
- R3: After reset, or after the divider leaves HOLD, the first pulse is high in the (N+1)-th clock after the first edge at which nothing stops the divider.
- R4: When B <= A, `cfg_err` goes high at the first clock edge after the setting is applied, and `div_pulse` stays low while the setting stays illegal.
- R5: The 8/9 mode combined with `vco_hi_band`=1 is flagged as an error. The 16/17 and 32/33 modes run normally with `vco_hi_band`=1.
- R6: `psc_mode`=3 is reserved and is flagged as a configuration error.
- R7: While `freeze` is high, no pulse is produced. After release, counting restarts from zero (timing as in R3).
- R8: `sync_sel` bit 0 set: while `sync_req` is high, the A/B counters and the prescaler are held cleared, and they restart on release (timing as in R3). Bit 0 clear: `sync_req` leaves the pulse train unchanged.
- R9: `ref_div_rst` is high exactly while `sync_req` is high and `sync_sel` bit 1 is set.
- R10: A new A, B or P applied in mid-period does not change the period in progress. The period that follows uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed divider clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_mode | input | 2 | Prescaler mode: 0 = 8/9, 1 = 16/17, 2 = 32/33, 3 = reserved |
| a_val | input | A_W | Swallow count A |
| b_val | input | B_W | Main count B |
| vco_hi_band | input | 1 | Oscillator above the 8/9 mode limit |
| sync_req | input | 1 | SYNC request, active high |
| sync_sel | input | 2 | Bit 0: SYNC clears the A/B counters; bit 1: SYNC resets the reference divider |
| freeze | input | 1 | Hold the divider in reset (opens the loop) |
| div_pulse | output | 1 | One-clock pulse per N input clocks |
| cfg_err | output | 1 | Registered illegal-setting flag |
| ref_div_rst | output | 1 | Reset request to the reference divider |

## Verification
The bench builds the divider with A_W=4 and B_W=10, which keeps the full counter range within the run time. With those widths the largest ratio, 32*1023+15, can be measured end to end, and so can the 5500 example. A near-exhaustive sweep then covers every prescaler mode against small A values with B just above A. That sweep includes A=0, the minimal B=A+1, and each DRAIN transition. Expected periods and first-pulse latencies come from N = P*B + A computed in the bench.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int PSC_CNT_W = 6;

    typedef enum logic [1:0] {
        FD_HOLD    = 2'd0,
        FD_SWALLOW = 2'd1,
        FD_MAIN    = 2'd2
    } fdiv_state_e;

    typedef enum logic [1:0] {
        PSC_8_9   = 2'd0,
        PSC_16_17 = 2'd1,
        PSC_32_33 = 2'd2,
        PSC_RSVD  = 2'd3
    } psc_mode_e;

    function automatic logic [PSC_CNT_W-1:0] psc_base(input logic [1:0] mode);
        logic [PSC_CNT_W-1:0] r;
        unique case (mode)
            PSC_8_9:   r = PSC_CNT_W'(8);
            PSC_16_17: r = PSC_CNT_W'(16);
            PSC_32_33: r = PSC_CNT_W'(32);
            default:   r = PSC_CNT_W'(8);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fdiv_cfg_check.sv
module fdiv_cfg_check #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic [1:0]     mode,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           vco_hi,
    output logic           err
);
    import fdiv_pkg::*;

    localparam int CMP_W = (A_W > B_W) ? A_W : B_W;

    logic [CMP_W-1:0] a_ext;
    logic [CMP_W-1:0] b_ext;
    logic             bad_order;
    logic             bad_mode;
    logic             bad_band;

    always_comb begin
        a_ext     = CMP_W'(a_in);
        b_ext     = CMP_W'(b_in);
        bad_order = (b_ext <= a_ext);
        bad_mode  = (mode == PSC_RSVD);
        bad_band  = (mode == PSC_8_9) && vco_hi;
        err       = bad_order | bad_mode | bad_band;
    end

endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] base,
    input  logic             plus_one,
    output logic             tick
);
    logic [CNT_W-1:0] pc;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = base + CNT_W'(plus_one);
        tick = run && (pc == lim - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (!run || tick) begin
            pc <= '0;
        end else begin
            pc <= pc + CNT_W'(1);
        end
    end

    AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pc < lim)); // R1

endmodule

// File: rtl/fdiv_swallow_fsm.sv
module fdiv_swallow_fsm #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           stop,
    input  logic                           tick,
    input  logic [1:0]                     mode_in,
    input  logic [A_W-1:0]                 a_in,
    input  logic [B_W-1:0]                 b_in,
    output logic                           run,
    output logic                           plus_one,
    output logic [fdiv_pkg::PSC_CNT_W-1:0] base,
    output logic                           terminal
);
    import fdiv_pkg::*;

    fdiv_state_e          state;
    fdiv_state_e          nxt;
    logic [A_W-1:0]       a_cnt;
    logic [B_W-1:0]       b_cnt;
    logic [PSC_CNT_W-1:0] base_q;
    logic                 load;
    logic                 start_a;

    always_comb begin
        start_a = (a_in != '0);
        nxt     = state;
        unique case (state)
            FD_HOLD: begin
                if (!stop) nxt = start_a ? FD_SWALLOW : FD_MAIN;       // START
            end
            FD_SWALLOW: begin
                if (stop) nxt = FD_HOLD;                               // HALT
                else if (tick && a_cnt == A_W'(1)) nxt = FD_MAIN;      // DRAIN
            end
            FD_MAIN: begin
                if (stop) nxt = FD_HOLD;                               // HALT
                else if (terminal) nxt = start_a ? FD_SWALLOW : FD_MAIN; // WRAP
            end
            default: nxt = FD_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FD_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        run      = (state != FD_HOLD);
        plus_one = (state == FD_SWALLOW);
        base     = base_q;
        terminal = (state == FD_MAIN) && tick && (b_cnt == B_W'(1));
        load     = !stop && ((state == FD_HOLD) || terminal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cnt  <= '0;
            b_cnt  <= '0;
            base_q <= psc_base(2'd0);
        end else if (load) begin
            a_cnt  <= a_in;
            b_cnt  <= b_in;
            base_q <= psc_base(mode_in);
        end else if (state == FD_HOLD) begin
            a_cnt  <= '0;
            b_cnt  <= '0;
        end else if (tick) begin
            b_cnt <= b_cnt - B_W'(1);
            if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
        end
    end

    AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FD_HOLD) |-> (B_W'(a_cnt) < b_cnt)); // R4
    AST_MAIN_NO_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FD_MAIN) |-> (a_cnt == '0)); // R1

endmodule

// File: rtl/fdiv_dual_mod.sv
module fdiv_dual_mod #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     psc_mode,
    input  logic [A_W-1:0] a_val,
    input  logic [B_W-1:0] b_val,
    input  logic           vco_hi_band,
    input  logic           sync_req,
    input  logic [1:0]     sync_sel,
    input  logic           freeze,
    output logic           div_pulse,
    output logic           cfg_err,
    output logic           ref_div_rst
);
    import fdiv_pkg::*;

    logic                 err_c;
    logic                 stop;
    logic                 tick;
    logic                 run;
    logic                 plus_one;
    logic                 terminal;
    logic [PSC_CNT_W-1:0] base;
    logic                 pulse_q;
    logic                 err_q;

    fdiv_cfg_check #(.A_W(A_W), .B_W(B_W)) u_check (
        .mode   (psc_mode),
        .a_in   (a_val),
        .b_in   (b_val),
        .vco_hi (vco_hi_band),
        .err    (err_c)
    );

    always_comb begin
        stop        = freeze | err_c | (sync_req & sync_sel[0]);
        ref_div_rst = sync_req & sync_sel[1];
    end

    fdiv_prescaler #(.CNT_W(PSC_CNT_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .base     (base),
        .plus_one (plus_one),
        .tick     (tick)
    );

    fdiv_swallow_fsm #(.A_W(A_W), .B_W(B_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (stop),
        .tick     (tick),
        .mode_in  (psc_mode),
        .a_in     (a_val),
        .b_in     (b_val),
        .run      (run),
        .plus_one (plus_one),
        .base     (base),
        .terminal (terminal)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= terminal && !stop;
            err_q   <= err_c;
        end
    end

    always_comb begin
        div_pulse = pulse_q;
        cfg_err   = err_q;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R2
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !div_pulse); // R4
    AST_FREEZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !div_pulse); // R7
    AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && sync_sel[0]) |=> !div_pulse); // R8

endmodule

// File: tb/tb_fdiv_dual_mod.sv
module tb_fdiv_dual_mod;
    localparam int A_W = 4;
    localparam int B_W = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     psc_mode = 2'd0;
    logic [A_W-1:0] a_val = '0;
    logic [B_W-1:0] b_val = B_W'(1);
    logic           vco_hi_band = 1'b0;
    logic           sync_req = 1'b0;
    logic [1:0]     sync_sel = 2'b00;
    logic           freeze = 1'b1;
    logic           div_pulse;
    logic           cfg_err;
    logic           ref_div_rst;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fdiv_dual_mod #(.A_W(A_W), .B_W(B_W)) dut (
        .clk(clk), .rst_n(rst_n), .psc_mode(psc_mode), .a_val(a_val),
        .b_val(b_val), .vco_hi_band(vco_hi_band), .sync_req(sync_req),
        .sync_sel(sync_sel), .freeze(freeze), .div_pulse(div_pulse),
        .cfg_err(cfg_err), .ref_div_rst(ref_div_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input int m, input int a, input int b);
        int p;
        p = (m == 0) ? 8 : (m == 1) ? 16 : 32;
        return p * b + a;
    endfunction

    // counts negedges until div_pulse is seen high, capped at lim
    task automatic wait_pulse(output int cnt, input int lim);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!div_pulse && cnt < lim);
    endtask

    task automatic set_cfg(input int m, input int a, input int b);
        psc_mode = 2'(m);
        a_val    = A_W'(a);
        b_val    = B_W'(b);
    endtask

    // R1 R2 R3: restart from freeze, check latency, width, spacing
    task automatic run_cfg(input int m, input int a, input int b);
        int n;
        int c;
        n = ratio(m, a, b);
        @(negedge clk);
        freeze = 1'b1;
        set_cfg(m, a, b);
        @(negedge clk);
        freeze = 1'b0;
        wait_pulse(c, n + 20);
        chk(c == n + 1, "R3 first pulse latency", c, n + 1);
        @(negedge clk);
        chk(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
        wait_pulse(c, n + 20);
        chk(c + 1 == n, "R1 pulse spacing", c + 1, n);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int c;
        int n;
        int seen;
        repeat (3) @(negedge clk);
        chk(div_pulse == 1'b0, "R3 reset pulse low", int'(div_pulse), 0);
        chk(cfg_err == 1'b0, "R4 reset err low", int'(cfg_err), 0);
        chk(ref_div_rst == 1'b0, "R9 reset ref rst low", int'(ref_div_rst), 0);

        // R3: first pulse after reset release
        set_cfg(0, 1, 2);
        freeze = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_pulse(c, 100);
        chk(c == ratio(0, 1, 2) + 1, "R3 latency after reset", c, ratio(0, 1, 2) + 1);

        // R1: sweep of modes, small A, B just above A
        for (int m = 0; m < 3; m++)
            for (int a = 0; a < 4; a++)
                for (int d = 1; d < 4; d++)
                    run_cfg(m, a, a + d);

        run_cfg(0, 4, 687);    // R1 5500 example
        run_cfg(2, 15, 1023);  // R1 largest ratio

        // R5: high band legal for 16/17 and 32/33
        vco_hi_band = 1'b1;
        run_cfg(1, 2, 5);
        chk(cfg_err == 1'b0, "R5 16/17 high band legal", int'(cfg_err), 0);
        run_cfg(2, 1, 3);
        chk(cfg_err == 1'b0, "R5 32/33 high band legal", int'(cfg_err), 0);
        // R5: 8/9 with high band is illegal
        @(negedge clk);
        set_cfg(0, 1, 3);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R5 8/9 high band err", int'(cfg_err), 1);
        seen = 0;
        repeat (80) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        chk(seen == 0, "R5 no pulses", seen, 0);
        vco_hi_band = 1'b0;
        wait_pulse(c, 100);
        chk(c == ratio(0, 1, 3) + 1, "R5 recovery latency", c, ratio(0, 1, 3) + 1);

        // R4: B equal to A, then B below A
        @(negedge clk);
        set_cfg(1, 3, 3);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R4 B==A err", int'(cfg_err), 1);
        b_val = B_W'(2);
        seen = 0;
        repeat (100) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        chk(seen == 0, "R4 no pulses", seen, 0);
        chk(cfg_err == 1'b1, "R4 B<A err", int'(cfg_err), 1);
        b_val = B_W'(4);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R4 err clears", int'(cfg_err), 0);

        // R6: reserved mode
        run_cfg(0, 0, 3);
        @(negedge clk);
        set_cfg(3, 0, 3);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R6 reserved mode err", int'(cfg_err), 1);
        seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        chk(seen == 0, "R6 no pulses", seen, 0);

        // R7: freeze stops output, restart timing
        run_cfg(0, 2, 4);
        @(negedge clk);
        freeze = 1'b1;
        seen = 0;
        repeat (100) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        chk(seen == 0, "R7 frozen no pulses", seen, 0);
        freeze = 1'b0;
        wait_pulse(c, 100);
        chk(c == ratio(0, 2, 4) + 1, "R7 restart latency", c, ratio(0, 2, 4) + 1);

        // R8 / R9: sync with counter reset disabled, ref reset enabled
        n = ratio(0, 2, 4);
        sync_sel = 2'b10;
        repeat (10) @(negedge clk);
        sync_req = 1'b1;
        #1;
        chk(ref_div_rst == 1'b1, "R9 ref reset follows sync", int'(ref_div_rst), 1);
        repeat (5) @(negedge clk);
        sync_req = 1'b0;
        #1;
        chk(ref_div_rst == 1'b0, "R9 ref reset drops", int'(ref_div_rst), 0);
        wait_pulse(c, n + 20);
        wait_pulse(c, n + 20);
        chk(c == n, "R8 sync ignored spacing", c, n);

        // R8 / R9: sync with counter reset enabled
        sync_sel = 2'b01;
        repeat (7) @(negedge clk);
        sync_req = 1'b1;
        #1;
        chk(ref_div_rst == 1'b0, "R9 ref reset off", int'(ref_div_rst), 0);
        seen = 0;
        repeat (50) begin
            @(negedge clk);
            if (div_pulse) seen++;
        end
        chk(seen == 0, "R8 sync holds counters", seen, 0);
        sync_req = 1'b0;
        wait_pulse(c, n + 20);
        chk(c == n + 1, "R8 sync realign latency", c, n + 1);
        sync_sel = 2'b00;

        // R10: mid-period change applies at next boundary
        run_cfg(1, 1, 3);
        repeat (10) @(negedge clk);
        set_cfg(2, 3, 5);
        wait_pulse(c, 200);
        chk(c + 10 == ratio(1, 1, 3), "R10 old period kept", c + 10, ratio(1, 1, 3));
        wait_pulse(c, 300);
        chk(c == ratio(2, 3, 5), "R10 new period used", c, ratio(2, 3, 5));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule